// File: doc/BRIEF.md
# Event-Stepped I2C Bus Master

This block is an I2C bus master that software steps one bus event at a time through a small 32-bit register file. Each event is a START, a repeated START, one byte sent, one byte received followed by an ACK or a NAK, or a STOP. When an event other than STOP finishes, the controller sets an interrupt flag and loads a one-byte status code. It then holds SCL low until software clears the flag. The same control write that clears the flag also picks the next event. A STOP raises no flag. Software sees that it has finished when the status returns to the idle code 0xF8.

Both bus lines are open-drain. An output enable of 1 pulls the line low, and the line's level comes back on a separate input. Bit timing comes from a one-cycle `tick` strobe that an outside divider supplies. Every bit takes four ticks. If a slave stretches the clock, the engine waits in the SCL-high phase until `scl_in` reads high.

The engine is a five-state machine:
- E_IDLE: bus free. It goes to E_START on a START command.
- E_START: four ticks that release SDA, release SCL, pull SDA low and then pull SCL low. It then goes to E_HOLD.
- E_BIT: nine four-tick bit slots, eight data bits and then the acknowledge slot. It then goes to E_HOLD.
- E_HOLD: bus owned, SCL low. A START command goes to E_START, a STOP command goes to E_STOP, and any other command goes to E_BIT.
- E_STOP: three ticks that pull SDA low, release SCL and release SDA. It then goes to E_IDLE.

A write to the soft-reset offset sends every state straight to E_IDLE.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0xF8, the control register (offset 0x08) reads 0, both output enables are 0 and `irq` is 0.
- R2: Values written to offsets 0x00 and 0x10 read back unchanged in bits 7:0. A write to 0x0C does not change the status. The control bits are ACK=bit 2, flag=bit 3, STOP=bit 4, START=bit 5, enable=bit 6 and interrupt enable=bit 7. ACK, enable and interrupt enable read back as written, and START and STOP read back as 0.
- R3: A control write with START and enable both set, issued on an idle bus, produces a START condition and then status 0x08 with the flag set. The same write with enable clear does nothing.
- R4: The byte written to offset 0x04 is sent MSB first as the address byte after a START, and bit 0 of that byte gives the direction. The resulting status is 0x18 (write, ACK), 0x20 (write, NAK), 0x40 (read, ACK) or 0x48 (read, NAK).
- R5: In a write transfer, a data byte ends with status 0x28 if the slave drives ACK and 0x30 if it does not.
- R6: In a read transfer, a byte command receives eight bits. If ACK (bit 2) was set in the launching write, the master drives ACK in the ninth slot and the status is 0x50. Otherwise it leaves SDA released and the status is 0x58. The received byte is readable at 0x04 once the flag is set.
- R7: START while the bus is held produces a repeated START without any STOP and reports 0x10.
- R8: STOP produces a STOP condition, never sets the flag, returns the status to 0xF8 and releases both lines.
- R9: The status code of an event is already in place in the cycle the flag becomes set.
- R10: While the flag is set, SCL is held low.
- R11: With the default FLAG_W1C=0 the flag is cleared by writing 0 to bit 3. A control write that has bit 3 at 1 keeps the flag set and launches nothing. With FLAG_W1C=1 the polarity is inverted.
- R12: Any write to offset 0x1C returns the controller to idle. Status becomes 0xF8, control and both address registers become 0, and both lines are released.
- R13: `irq` is high only while the flag is set and interrupt enable is 1. The flag itself stays visible in control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-timing strobe, one quarter bit per pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A wrong direction or context bit inside the engine shows up at the next flag as the wrong status family, for example 0x28 where 0x50 was due. It also shows up on the bus, because SDA is either driven or released where the slave expects the opposite. That is at most 36 ticks after the launching write. A shift or bit-count error appears as a wrong byte captured by the bench slave, or as a wrong value at offset 0x04, when the acknowledge slot ends. A flag or hold error shows up within a cycle as SCL released while the flag is set, or as a flag after STOP.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] ST_START  = 8'h08;
    localparam logic [CODE_W-1:0] ST_RSTART = 8'h10;
    localparam logic [CODE_W-1:0] ST_AW_ACK = 8'h18;
    localparam logic [CODE_W-1:0] ST_AW_NAK = 8'h20;
    localparam logic [CODE_W-1:0] ST_DW_ACK = 8'h28;
    localparam logic [CODE_W-1:0] ST_DW_NAK = 8'h30;
    localparam logic [CODE_W-1:0] ST_AR_ACK = 8'h40;
    localparam logic [CODE_W-1:0] ST_AR_NAK = 8'h48;
    localparam logic [CODE_W-1:0] ST_DR_ACK = 8'h50;
    localparam logic [CODE_W-1:0] ST_DR_NAK = 8'h58;
    localparam logic [CODE_W-1:0] ST_IDLE   = 8'hF8;

    localparam int C_ACK   = 2;
    localparam int C_FLAG  = 3;
    localparam int C_STOP  = 4;
    localparam int C_START = 5;
    localparam int C_EN    = 6;
    localparam int C_IEN   = 7;

    localparam logic [4:0] A_SLV  = 5'h00;
    localparam logic [4:0] A_DATA = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C;
    localparam logic [4:0] A_XSLV = 5'h10;
    localparam logic [4:0] A_SRST = 5'h1C;

    typedef enum logic [2:0] {E_IDLE, E_START, E_BIT, E_HOLD, E_STOP} eng_state_t;
    typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_BYTE} cmd_t;
    typedef enum logic [1:0] {M_ADDR, M_TX, M_RX} ctx_t;
endpackage

// File: rtl/i2c_step_engine.sv
module i2c_step_engine
    import i2c_step_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              tick,
    input  logic              go,
    input  cmd_t              go_kind,
    input  logic [BYTE_W-1:0] go_byte,
    input  logic              go_ack,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              ready,
    output logic              ev_valid,
    output logic [CODE_W-1:0] ev_code,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              stop_done,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

    eng_state_t        state_q, state_d;
    logic [1:0]        phase_q, phase_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [BYTE_W-1:0] shift_q, shift_d;
    ctx_t              ctx_q, ctx_d;
    logic dir_q, dir_d, ackr_q, ackr_d, nak_q, nak_d, rst_q, rst_d;
    logic scl_low_q, scl_low_d, sda_low_q, sda_low_d;

    always_comb begin
        state_d = state_q;  phase_d = phase_q;  bit_d = bit_q;  shift_d = shift_q;
        ctx_d = ctx_q;  dir_d = dir_q;  ackr_d = ackr_q;  nak_d = nak_q;  rst_d = rst_q;
        scl_low_d = scl_low_q;  sda_low_d = sda_low_q;
        ev_valid = 1'b0;  ev_code = ST_IDLE;  rx_load = 1'b0;  stop_done = 1'b0;
        unique case (state_q)
            E_IDLE: begin
                if (go && go_kind == CMD_START) begin
                    state_d = E_START;  phase_d = 2'd0;  rst_d = 1'b0;
                end
            end
            E_HOLD: begin
                if (go) begin
                    phase_d = 2'd0;
                    unique case (go_kind)
                        CMD_START: begin state_d = E_START; rst_d = 1'b1; end
                        CMD_STOP:  state_d = E_STOP;
                        default: begin
                            state_d = E_BIT;  bit_d = '0;  shift_d = go_byte;
                            dir_d = go_byte[0];  ackr_d = go_ack;
                        end
                    endcase
                end
            end
            E_START: begin
                if (tick) begin
                    unique case (phase_q)
                        2'd0: begin sda_low_d = 1'b0; phase_d = 2'd1; end
                        2'd1: begin scl_low_d = 1'b0; phase_d = 2'd2; end
                        2'd2: if (scl_in) begin sda_low_d = 1'b1; phase_d = 2'd3; end
                        default: begin
                            scl_low_d = 1'b1;  state_d = E_HOLD;  ctx_d = M_ADDR;
                            ev_valid = 1'b1;  ev_code = rst_q ? ST_RSTART : ST_START;
                        end
                    endcase
                end
            end
            E_BIT: begin
                if (tick) begin
                    unique case (phase_q)
                        2'd0: begin
                            if (bit_q == ACK_SLOT) sda_low_d = (ctx_q == M_RX) && ackr_q;
                            else sda_low_d = (ctx_q != M_RX) && !shift_q[BYTE_W-1];
                            phase_d = 2'd1;
                        end
                        2'd1: begin scl_low_d = 1'b0; phase_d = 2'd2; end
                        2'd2: begin
                            if (scl_in) begin
                                if (bit_q == ACK_SLOT) nak_d = sda_in;
                                else shift_d = {shift_q[BYTE_W-2:0], sda_in};
                                phase_d = 2'd3;
                            end
                        end
                        default: begin
                            scl_low_d = 1'b1;  phase_d = 2'd0;
                            if (bit_q == ACK_SLOT) begin
                                state_d = E_HOLD;  ev_valid = 1'b1;
                                unique case (ctx_q)
                                    M_ADDR: begin
                                        ctx_d = dir_q ? M_RX : M_TX;
                                        if (dir_q) ev_code = nak_q ? ST_AR_NAK : ST_AR_ACK;
                                        else       ev_code = nak_q ? ST_AW_NAK : ST_AW_ACK;
                                    end
                                    M_TX: ev_code = nak_q ? ST_DW_NAK : ST_DW_ACK;
                                    default: begin
                                        ev_code = ackr_q ? ST_DR_ACK : ST_DR_NAK;
                                        rx_load = 1'b1;
                                    end
                                endcase
                            end else begin
                                bit_d = bit_q + 1'b1;
                            end
                        end
                    endcase
                end
            end
            E_STOP: begin
                if (tick) begin
                    unique case (phase_q)
                        2'd0: begin sda_low_d = 1'b1; phase_d = 2'd1; end
                        2'd1: begin scl_low_d = 1'b0; phase_d = 2'd2; end
                        default: begin
                            sda_low_d = 1'b0;  state_d = E_IDLE;  stop_done = 1'b1;
                        end
                    endcase
                end
            end
            default: state_d = E_IDLE;
        endcase
        if (srst) begin
            state_d = E_IDLE;  phase_d = 2'd0;  bit_d = '0;  shift_d = '0;  ctx_d = M_ADDR;
            dir_d = 1'b0;  ackr_d = 1'b0;  nak_d = 1'b0;  rst_d = 1'b0;
            scl_low_d = 1'b0;  sda_low_d = 1'b0;
            ev_valid = 1'b0;  rx_load = 1'b0;  stop_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= E_IDLE;  phase_q <= 2'd0;  bit_q <= '0;  shift_q <= '0;  ctx_q <= M_ADDR;
            dir_q <= 1'b0;  ackr_q <= 1'b0;  nak_q <= 1'b0;  rst_q <= 1'b0;
            scl_low_q <= 1'b0;  sda_low_q <= 1'b0;
        end else begin
            state_q <= state_d;  phase_q <= phase_d;  bit_q <= bit_d;  shift_q <= shift_d;
            ctx_q <= ctx_d;  dir_q <= dir_d;  ackr_q <= ackr_d;  nak_q <= nak_d;  rst_q <= rst_d;
            scl_low_q <= scl_low_d;  sda_low_q <= sda_low_d;
        end
    end

    assign ready   = (state_q == E_IDLE) || (state_q == E_HOLD);
    assign rx_byte = shift_q;
    assign scl_oe  = scl_low_q;
    assign sda_oe  = sda_low_q;
endmodule

// File: rtl/i2c_step_regs.sv
module i2c_step_regs
    import i2c_step_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int BYTE_W   = 8,
    parameter bit FLAG_W1C = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_ready,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              stop_done,
    output logic              srst,
    output logic              go,
    output cmd_t              go_kind,
    output logic [BYTE_W-1:0] go_byte,
    output logic              go_ack,
    output logic              flag,
    output logic [CODE_W-1:0] status,
    output logic              irq
);
    logic [BYTE_W-1:0] slv_q, xslv_q, data_q;
    logic [CODE_W-1:0] stat_q;
    logic ack_q, en_q, ien_q, flag_q;
    logic wr_ctrl, clr_req, flag_kept;
    logic [CODE_W-1:0] ctrl_view;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:BYTE_W];
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign srst    = reg_wr && (reg_addr == ADDR_W'(A_SRST));

    generate
        if (FLAG_W1C) begin : g_clear_by_one
            assign clr_req = reg_wdata[C_FLAG];
        end else begin : g_clear_by_zero
            assign clr_req = ~reg_wdata[C_FLAG];
        end
    endgenerate

    assign flag_kept = flag_q & ~clr_req;
    assign go      = wr_ctrl && reg_wdata[C_EN] && !flag_kept && eng_ready;
    assign go_kind = reg_wdata[C_START] ? CMD_START : (reg_wdata[C_STOP] ? CMD_STOP : CMD_BYTE);
    assign go_byte = data_q;
    assign go_ack  = reg_wdata[C_ACK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q <= '0;  xslv_q <= '0;  data_q <= '0;  stat_q <= ST_IDLE;
            ack_q <= 1'b0;  en_q <= 1'b0;  ien_q <= 1'b0;  flag_q <= 1'b0;
        end else if (srst) begin
            slv_q <= '0;  xslv_q <= '0;  data_q <= '0;  stat_q <= ST_IDLE;
            ack_q <= 1'b0;  en_q <= 1'b0;  ien_q <= 1'b0;  flag_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(A_SLV))  slv_q  <= reg_wdata[BYTE_W-1:0];
            if (reg_wr && reg_addr == ADDR_W'(A_XSLV)) xslv_q <= reg_wdata[BYTE_W-1:0];
            if (rx_load) data_q <= rx_byte;
            else if (reg_wr && reg_addr == ADDR_W'(A_DATA)) data_q <= reg_wdata[BYTE_W-1:0];
            if (ev_valid) stat_q <= ev_code;
            else if (stop_done) stat_q <= ST_IDLE;
            if (ev_valid) flag_q <= 1'b1;
            else if (wr_ctrl) flag_q <= flag_kept;
            if (wr_ctrl) begin
                ack_q <= reg_wdata[C_ACK];  en_q <= reg_wdata[C_EN];  ien_q <= reg_wdata[C_IEN];
            end
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[C_ACK]  = ack_q;
        ctrl_view[C_FLAG] = flag_q;
        ctrl_view[C_EN]   = en_q;
        ctrl_view[C_IEN]  = ien_q;
        case (reg_addr)
            ADDR_W'(A_SLV):  reg_rdata = DATA_W'(slv_q);
            ADDR_W'(A_DATA): reg_rdata = DATA_W'(data_q);
            ADDR_W'(A_CTRL): reg_rdata = DATA_W'(ctrl_view);
            ADDR_W'(A_STAT): reg_rdata = DATA_W'(stat_q);
            ADDR_W'(A_XSLV): reg_rdata = DATA_W'(xslv_q);
            default:         reg_rdata = '0;
        endcase
    end

    assign flag   = flag_q;
    assign status = stat_q;
    assign irq    = flag_q & ien_q;
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
    import i2c_step_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int BYTE_W   = 8,
    parameter bit FLAG_W1C = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    input  logic              scl_in,
    output logic              sda_oe,
    input  logic              sda_in
);
    logic srst_w, go_w, go_ack_w, ready_w, ev_valid_w, rx_load_w, stop_done_w, flag_w;
    cmd_t go_kind_w;
    logic [BYTE_W-1:0] go_byte_w, rx_byte_w;
    logic [CODE_W-1:0] ev_code_w, status_w;

    i2c_step_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .FLAG_W1C(FLAG_W1C)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_ready(ready_w),
        .ev_valid(ev_valid_w), .ev_code(ev_code_w), .rx_load(rx_load_w),
        .rx_byte(rx_byte_w), .stop_done(stop_done_w), .srst(srst_w), .go(go_w),
        .go_kind(go_kind_w), .go_byte(go_byte_w), .go_ack(go_ack_w),
        .flag(flag_w), .status(status_w), .irq(irq)
    );

    i2c_step_engine #(.BYTE_W(BYTE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .srst(srst_w), .tick(tick), .go(go_w),
        .go_kind(go_kind_w), .go_byte(go_byte_w), .go_ack(go_ack_w),
        .scl_in(scl_in), .sda_in(sda_in), .ready(ready_w), .ev_valid(ev_valid_w),
        .ev_code(ev_code_w), .rx_load(rx_load_w), .rx_byte(rx_byte_w),
        .stop_done(stop_done_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              flag,
    input logic [7:0]        status,
    input logic              scl_oe,
    input logic              irq
);
    // R10: master stretches SCL for as long as the flag is up
    p_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> scl_oe);

    // R9: the code is already loaded when the flag rises
    p_code_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (status != 8'hF8));

    // R8: returning to idle status never comes with a flag
    p_stop_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'hF8 && $past(status) != 8'hF8) |-> !flag);

    // R11: only a register write can take the flag down
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !reg_wr) |=> flag);

    // R12: soft reset leaves idle status and no flag
    p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(5'h1C)) |=> (status == 8'hF8 && !flag));

    // R13: no request without a pending flag
    p_irq_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind i2c_step_master i2c_step_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .flag(flag_w), .status(status_w), .scl_oe(scl_oe), .irq(irq)
);

// File: tb/i2c_step_master_tb_top.sv
module i2c_step_master_tb_top;
    localparam logic [6:0] SLV_ADDR = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'h0C;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic slv_sda_low = 1'b0;
    logic scl_line, sda_line;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_sda_low);

    always #5 clk = ~clk;

    i2c_step_master dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
        .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 2;
        tick = (tdiv == 0);
    end

    // ---------------- behavioural slave ----------------
    logic scl_p = 1'b1, sda_p = 1'b1;
    bit slv_active = 0, slv_is_addr = 0, slv_rd = 0, slv_ack_en = 1;
    int slv_cnt = 0, slv_idx = 0;
    logic [7:0] slv_sh = '0, got_addr = '0, got_byte = '0;
    logic [7:0] slv_mem [16];

    always @(scl_line or sda_line) begin
        if (scl_line && scl_p && sda_p && !sda_line) begin
            slv_active = 1;  slv_is_addr = 1;  slv_cnt = 0;  slv_idx = 0;  slv_sda_low = 0;
        end else if (scl_line && scl_p && !sda_p && sda_line) begin
            slv_active = 0;  slv_sda_low = 0;
        end else if (scl_line && !scl_p && slv_active) begin
            if (slv_cnt < 8) begin
                slv_sh = {slv_sh[6:0], sda_line};  slv_cnt++;
            end else begin
                if (slv_is_addr) begin
                    got_addr = slv_sh;  slv_is_addr = 0;  slv_rd = slv_sh[0];
                    if (slv_sh[7:1] != SLV_ADDR) begin slv_active = 0; slv_sda_low = 0; end
                end else if (slv_rd) begin
                    slv_idx++;
                    if (sda_line) begin slv_active = 0; slv_sda_low = 0; end
                end else begin
                    got_byte = slv_sh;
                end
                slv_cnt = 0;
            end
        end else if (!scl_line && scl_p && slv_active) begin
            if (slv_cnt == 8) begin
                if (slv_is_addr) slv_sda_low = (slv_sh[7:1] == SLV_ADDR);
                else if (!slv_rd) slv_sda_low = slv_ack_en;
                else slv_sda_low = 0;
            end else if (slv_rd && !slv_is_addr) begin
                slv_sda_low = !slv_mem[slv_idx[3:0]][7 - slv_cnt];
            end else begin
                slv_sda_low = 0;
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // ---------------- expected-value functions ----------------
    function automatic logic [7:0] exp_addr_code(input logic [7:0] b, input bit acked);
        if (b[0]) return acked ? 8'h40 : 8'h48;
        return acked ? 8'h18 : 8'h20;
    endfunction
    function automatic logic [7:0] exp_tx_code(input bit acked);
        return acked ? 8'h28 : 8'h30;
    endfunction
    function automatic logic [7:0] exp_rx_code(input bit ack_sent);
        return ack_sent ? 8'h50 : 8'h58;
    endfunction

    // ---------------- tasks ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;  reg_addr = a;  reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;  reg_addr = 5'h0C;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 5'h0C;
    endtask

    // returns the status seen in the very cycle irq is first observed
    task automatic wait_flag(input string tag, output logic [7:0] st);
        int n = 0;
        reg_addr = 5'h0C;
        #1;
        while (!irq && n < 3000) begin
            @(negedge clk);
            #1;
            n++;
        end
        st = reg_rdata[7:0];
        if (!irq) check({tag, " flag timeout"}, 32'd0, 32'd1);
    endtask

    task automatic op(input logic [7:0] ctrl, input logic [7:0] exp, input string tag);
        logic [7:0] st;
        wr(5'h08, {24'd0, ctrl});
        wait_flag(tag, st);
        check(tag, {24'd0, st}, {24'd0, exp});
    endtask

    task automatic send(input logic [7:0] b, input logic [7:0] exp, input string tag);
        wr(5'h04, {24'd0, b});
        op(8'hC0, exp, tag);
    endtask

    task automatic stop_bus(input string tag);
        int n = 0;
        bit saw_irq = 0;
        wr(5'h08, 32'hD0);
        #1;
        while (reg_rdata[7:0] != 8'hF8 && n < 3000) begin
            @(negedge clk);
            #1;
            if (irq) saw_irq = 1;
            n++;
        end
        check({tag, " status idle"}, reg_rdata, 32'hF8);
        check({tag, " no flag"}, {31'd0, saw_irq | irq}, 32'd0);
        repeat (4) @(negedge clk);
        check({tag, " lines released"}, {30'd0, scl_oe, sda_oe}, 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0] st, b;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) slv_mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(5'h0C, v);  check("R1 status", v, 32'hF8);
        rd(5'h08, v);  check("R1 control", v, 32'h0);
        check("R1 lines/irq", {29'd0, scl_oe, sda_oe, irq}, 32'd0);

        // R2 register map
        wr(5'h00, 32'h5A);  rd(5'h00, v);  check("R2 slave addr", v, 32'h5A);
        wr(5'h10, 32'h33);  rd(5'h10, v);  check("R2 ext addr", v, 32'h33);
        wr(5'h0C, 32'h12);  rd(5'h0C, v);  check("R2 status unaffected", v, 32'hF8);
        wr(5'h08, 32'h84);  rd(5'h08, v);  check("R2 control readback", v, 32'h84);

        // R3 START without enable is ignored
        wr(5'h08, 32'hA0);
        repeat (200) @(negedge clk);
        rd(5'h0C, v);  check("R3 disabled start status", v, 32'hF8);
        check("R3 disabled start lines", {29'd0, scl_oe, sda_oe, irq}, 32'd0);

        // R3 / R9 START
        wr(5'h08, 32'hE0);
        wait_flag("R9", st);
        check("R9 status with first flag", {24'd0, st}, 32'h08);
        rd(5'h08, v);  check("R3 control shows flag", v, 32'hC8);

        // R10 stretch
        repeat (60) @(negedge clk);
        check("R10 scl held low", {31'd0, scl_oe}, 32'd1);

        // R11 writing 1 to flag keeps it
        wr(5'h08, 32'hC8);
        repeat (100) @(negedge clk);
        check("R11 flag kept", {31'd0, irq}, 32'd1);
        rd(5'h0C, v);  check("R11 status unchanged", v, 32'h08);
        check("R11 scl still low", {31'd0, scl_oe}, 32'd1);

        // R4 address write, R5 data
        slv_ack_en = 1;
        send({SLV_ADDR, 1'b0}, exp_addr_code({SLV_ADDR, 1'b0}, 1), "R4 addr write ack");
        check("R4 address on bus", {24'd0, got_addr}, {24'd0, SLV_ADDR, 1'b0});
        send(8'hA5, exp_tx_code(1), "R5 data ack");
        check("R5 byte on bus", {24'd0, got_byte}, 32'hA5);
        slv_ack_en = 0;
        send(8'h3C, exp_tx_code(0), "R5 data nak");

        // R7 repeated START, then read
        op(8'hE0, 8'h10, "R7 repeated start");
        slv_mem[0] = 8'h96;  slv_mem[1] = 8'h5B;
        send({SLV_ADDR, 1'b1}, exp_addr_code({SLV_ADDR, 1'b1}, 1), "R4 addr read ack");
        op(8'hC4, exp_rx_code(1), "R6 rx ack");
        rd(5'h04, v);  check("R6 rx byte 0", v, 32'h96);
        check("R6 ack driven", {31'd0, sda_oe}, 32'd1);
        op(8'hC0, exp_rx_code(0), "R6 rx nak");
        rd(5'h04, v);  check("R6 rx byte 1", v, 32'h5B);
        stop_bus("R8");

        // R4 address NAK both directions
        op(8'hE0, 8'h08, "R3 start");
        send(8'h22, exp_addr_code(8'h22, 0), "R4 addr write nak");
        op(8'hE0, 8'h10, "R7 repeated start 2");
        send(8'h23, exp_addr_code(8'h23, 0), "R4 addr read nak");
        stop_bus("R8 after nak");

        // R13 irq masked while flag visible
        wr(5'h08, 32'h60);
        repeat (300) @(negedge clk);
        check("R13 irq masked", {31'd0, irq}, 32'd0);
        rd(5'h08, v);  check("R13 flag visible", v, 32'h48);
        rd(5'h0C, v);  check("R13 status", v, 32'h08);
        stop_bus("R8 masked");

        // random write transfers
        for (int t = 0; t < 8; t++) begin
            int nb;
            nb = 1 + ($urandom % 3);
            op(8'hE0, 8'h08, "R3 rand start");
            slv_ack_en = 1;
            send({SLV_ADDR, 1'b0}, 8'h18, "R4 rand addr");
            for (int k = 0; k < nb; k++) begin
                bit a;
                a = ($urandom % 4) != 0;
                slv_ack_en = a;
                b = 8'($urandom);
                send(b, exp_tx_code(a), "R5 rand data");
                if (a) check("R5 rand byte", {24'd0, got_byte}, {24'd0, b});
            end
            stop_bus("R8 rand");
        end

        // random read transfers
        for (int t = 0; t < 6; t++) begin
            int nb;
            nb = 1 + ($urandom % 4);
            for (int k = 0; k < 16; k++) slv_mem[k] = 8'($urandom);
            op(8'hE0, 8'h08, "R3 rand start rd");
            send({SLV_ADDR, 1'b1}, 8'h40, "R4 rand addr rd");
            for (int k = 0; k < nb; k++) begin
                bit last;
                last = (k == nb - 1);
                op(last ? 8'hC0 : 8'hC4, exp_rx_code(!last), "R6 rand rx");
                rd(5'h04, v);
                check("R6 rand rx byte", v, {24'd0, slv_mem[k]});
            end
            stop_bus("R8 rand rd");
        end

        // R12 soft reset in the middle of a transfer
        wr(5'h00, 32'h5A);
        op(8'hE0, 8'h08, "R3 start before reset");
        wr(5'h1C, 32'h0);
        slv_active = 0;
        rd(5'h0C, v);  check("R12 status", v, 32'hF8);
        rd(5'h08, v);  check("R12 control", v, 32'h0);
        rd(5'h00, v);  check("R12 slave addr", v, 32'h0);
        rd(5'h10, v);  check("R12 ext addr", v, 32'h0);
        check("R12 lines/irq", {29'd0, scl_oe, sda_oe, irq}, 32'd0);
        wr(5'h08, 32'hE0);
        wait_flag("R12", st);
        check("R12 start after reset", {24'd0, st}, 32'h08);
        stop_bus("R8 final");

        finish_run();
    end
endmodule